// File: doc/BRIEF.md
# One-Wire Byte Shift Engine

This block turns byte-wide register writes into eight one-wire bit slots and gathers the bus level seen in each slot into a received byte. It sits above a separate bit-slot generator. For each slot it raises a one-cycle start request with the bit to drive. The generator answers with a done pulse and the sampled bus level. Bits go out least significant first.

Reading from the bus needs no separate command. Write-1 slots leave the line free, so a device can pull it low. Writing 0xFF therefore clocks eight device bits into the receive path. Four flags track the transmit buffer, the transmit shifter, the receive buffer and the receive shifter. An interrupt line is raised when any flag whose enable bit is set is active.

The register window has 2-bit addresses:

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | data | queues a byte | last received byte, and clears the receive-buffer-full flag |
| 1 | status | no effect | the four flags, no side effect |
| 2 | enable | sets the interrupt enables | the interrupt enables |
| 3 | none | no effect | zero |

Top module: `ow_byte_engine`

## Requirements
- R1: After reset, status reads 0x0C: bit 2 (transmit buffer empty) and bit 3 (transmit shifter empty) are set, and bit 4 and bit 5 are clear. The enable register reads 0, `irq_o` is low and `slot_start_o` is low.
- R2: A write to address 0 clears status bit 2 on the next clock edge. On the edge after that, if the shifter is idle, the byte moves into the shifter, bit 2 sets again and bit 3 clears.
- R3: A byte is sent as eight slots, least significant bit first. Each slot is a single-cycle `slot_start_o` pulse, and `slot_value_o` carries the bit and holds it until `slot_done_i`. The next pulse follows the cycle after `slot_done_i`.
- R4: The `slot_bit_i` level sampled in slot i becomes bit i of the received byte. Sending 0xFF reads a byte from the bus.
- R5: Status bit 3 sets on the edge that accepts the eighth `slot_done_i`.
- R6: On that same edge, status bit 4 sets and the new byte becomes readable at address 0. A read of address 0 clears bit 4, unless a byte completes in the same cycle; then the bit stays set.
- R7: Status bit 5 (receive shifter full) sets when a byte completes. It clears when the next byte is loaded into the shifter.
- R8: A write to address 2 keeps only bits 2 to 5 of the written value, and a read returns them. `irq_o` is high when any status bit is set whose enable bit at the same position is also set. Address 3 reads 0.
- R9: A byte written while another is shifting waits in the buffer, with status bit 2 clear. It is sent right after the current byte. Reading status has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_n_i | input | 1 | asynchronous reset, active low |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe (only address 0 has a side effect) |
| reg_addr_i | input | ADDR_W | register address: 0 data, 1 status, 2 enable |
| reg_wdata_i | input | REG_W | write data |
| reg_rdata_o | output | REG_W | read data for the addressed register (combinational) |
| slot_start_o | output | 1 | one-cycle request for a bit slot |
| slot_value_o | output | 1 | bit to drive in the requested slot |
| slot_done_i | input | 1 | slot finished (one-cycle pulse) |
| slot_bit_i | input | 1 | bus level sampled in the finished slot |
| irq_o | output | 1 | interrupt: status flags masked by the enable register |

## Verification
The bench is tried with three kinds of input.

- **Fully released bus.** A byte such as 0xA5 goes out onto a bus the device never pulls low. This separates the bit order and the slot handshake from the receive path.
- **Device pulls the line low.** The device pulls selected bits low during 0xFF and 0x0F transfers. This shows that received bits come from the bus and not from the transmit byte.
- **Overlapping traffic.** A second byte is written while one is shifting, and a data read is timed onto the completing edge. These show the buffer hand-over and the set-over-clear priority of the receive-full flag.

A behavioural model checks status, data, enable, the slot outputs and the interrupt on every cycle, with slot latencies of 1, 2 and 4 cycles.

// File: rtl/ow_byte_pkg.sv
package ow_byte_pkg;
   // status bit positions; the interrupt enable register uses the same positions
   localparam int unsigned ST_TX_BUF_EMPTY = 2;
   localparam int unsigned ST_TX_SHF_EMPTY = 3;
   localparam int unsigned ST_RX_BUF_FULL  = 4;
   localparam int unsigned ST_RX_SHF_FULL  = 5;
   localparam int unsigned ST_MSB          = ST_RX_SHF_FULL;
   localparam int unsigned ST_COUNT        = ST_MSB - ST_TX_BUF_EMPTY + 1;

   typedef enum logic [1:0] {
      REG_DATA   = 2'd0,
      REG_STATUS = 2'd1,
      REG_ENABLE = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_START = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/ow_byte_txbuf.sv
module ow_byte_txbuf #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              load_i,
   output logic [BYTE_W-1:0] buf_o,
   output logic              empty_o
);
   logic [BYTE_W-1:0] buf_q;
   logic              empty_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         buf_q   <= '0;
         empty_q <= 1'b1;
      end else begin
         if (wr_i) buf_q <= wdata_i;
         // a new write wins over the hand-over of the previous byte
         if (wr_i)        empty_q <= 1'b0;
         else if (load_i) empty_q <= 1'b1;
      end
   end

   assign buf_o   = buf_q;
   assign empty_o = empty_q;

   AST_TBE_FALL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $fell(empty_o) |-> $past(wr_i)) else $error("buffer filled without write"); // R2
   AST_TBE_RISE_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(empty_o) |-> $past(load_i)) else $error("buffer emptied without load"); // R2
endmodule

// File: rtl/ow_byte_seq.sv
module ow_byte_seq
   import ow_byte_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              pending_i,
   input  logic [BYTE_W-1:0] txbyte_i,
   input  logic              slot_done_i,
   input  logic              slot_bit_i,
   output logic              load_o,
   output logic              slot_start_o,
   output logic              slot_value_o,
   output logic              byte_done_o,
   output logic [BYTE_W-1:0] rx_next_o,
   output logic              tse_o,
   output logic              rsf_o
);
   localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   seq_state_e        state_q;
   logic [BYTE_W-1:0] tsh_q;
   logic [BYTE_W-1:0] rsh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              tse_q;
   logic              rsf_q;
   logic              slot_fin;

   assign load_o       = (state_q == SEQ_IDLE) && pending_i;
   assign slot_fin     = (state_q == SEQ_WAIT) && slot_done_i;
   assign byte_done_o  = slot_fin && (cnt_q == LAST_BIT);
   // sampled bit enters at the top so that after BYTE_W slots slot 0 sits in bit 0
   assign rx_next_o    = {slot_bit_i, rsh_q[BYTE_W-1:1]};
   assign slot_start_o = (state_q == SEQ_START);
   assign slot_value_o = tsh_q[0];
   assign tse_o        = tse_q;
   assign rsf_o        = rsf_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         state_q <= SEQ_IDLE;
         tsh_q   <= '0;
         rsh_q   <= '0;
         cnt_q   <= '0;
         tse_q   <= 1'b1;
         rsf_q   <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (pending_i) begin
                  tsh_q   <= txbyte_i;
                  cnt_q   <= '0;
                  tse_q   <= 1'b0;
                  rsf_q   <= 1'b0;
                  state_q <= SEQ_START;
               end
            end
            SEQ_START: state_q <= SEQ_WAIT;
            SEQ_WAIT: begin
               if (slot_done_i) begin
                  tsh_q <= tsh_q >> 1;
                  rsh_q <= rx_next_o;
                  if (cnt_q == LAST_BIT) begin
                     cnt_q   <= '0;
                     tse_q   <= 1'b1;
                     rsf_q   <= 1'b1;
                     state_q <= SEQ_IDLE;
                  end else begin
                     cnt_q   <= cnt_q + CNT_W'(1);
                     state_q <= SEQ_START;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      slot_start_o |=> !slot_start_o) else $error("slot start longer than one cycle"); // R3
   AST_VALUE_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == SEQ_WAIT) |-> $stable(slot_value_o)) else $error("slot value moved"); // R3
   AST_LOAD_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      load_o |-> tse_o) else $error("load while shifter busy"); // R2
   AST_TSE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(tse_o) |-> $past(slot_done_i)) else $error("shifter empty without slot done"); // R5
endmodule

// File: rtl/ow_byte_rxbuf.sv
module ow_byte_rxbuf #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              byte_done_i,
   input  logic [BYTE_W-1:0] rx_next_i,
   input  logic              rd_i,
   output logic [BYTE_W-1:0] data_o,
   output logic              full_o
);
   logic [BYTE_W-1:0] data_q;
   logic              full_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (byte_done_i) data_q <= rx_next_i;
         // a completing byte wins over a simultaneous drain
         if (byte_done_i) full_q <= 1'b1;
         else if (rd_i)   full_q <= 1'b0;
      end
   end

   assign data_o = data_q;
   assign full_o = full_q;

   AST_RBF_FALL_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $fell(full_o) |-> $past(rd_i)) else $error("receive full dropped without read"); // R6
   AST_RBF_RISE_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(full_o) |-> $past(byte_done_i)) else $error("receive full without byte"); // R6
endmodule

// File: rtl/ow_byte_engine.sv
module ow_byte_engine
   import ow_byte_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned REG_W  = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              slot_start_o,
   output logic              slot_value_o,
   input  logic              slot_done_i,
   input  logic              slot_bit_i,
   output logic              irq_o
);
   localparam logic [REG_W-1:0] EN_MASK = REG_W'((1 << ST_COUNT) - 1) << ST_TX_BUF_EMPTY;

   initial begin : p_param_check
      assert (BYTE_W >= 2) else $error("BYTE_W must be at least 2");
      assert (REG_W >= BYTE_W) else $error("REG_W must hold a byte");
      assert (REG_W > ST_MSB) else $error("REG_W must hold the status bits");
      assert (ADDR_W >= 2) else $error("ADDR_W must select four registers");
   end

   logic              sel_data, sel_stat, sel_en;
   logic              wr_data, rd_data;
   logic              tbe, tse, rbf, rsf;
   logic              load;
   logic              byte_done;
   logic [BYTE_W-1:0] tx_buf;
   logic [BYTE_W-1:0] rx_next;
   logic [BYTE_W-1:0] rx_data;
   logic [ST_COUNT-1:0] flag_v;
   logic [REG_W-1:0]  status_w;
   logic [REG_W-1:0]  en_q;

   assign sel_data = (reg_addr_i == ADDR_W'(REG_DATA));
   assign sel_stat = (reg_addr_i == ADDR_W'(REG_STATUS));
   assign sel_en   = (reg_addr_i == ADDR_W'(REG_ENABLE));
   assign wr_data  = reg_wr_i && sel_data;
   assign rd_data  = reg_rd_i && sel_data;

   ow_byte_txbuf #(.BYTE_W(BYTE_W)) i_txbuf (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .wr_i    (wr_data),
      .wdata_i (reg_wdata_i[BYTE_W-1:0]),
      .load_i  (load),
      .buf_o   (tx_buf),
      .empty_o (tbe)
   );

   ow_byte_seq #(.BYTE_W(BYTE_W)) i_seq (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .pending_i    (!tbe),
      .txbyte_i     (tx_buf),
      .slot_done_i  (slot_done_i),
      .slot_bit_i   (slot_bit_i),
      .load_o       (load),
      .slot_start_o (slot_start_o),
      .slot_value_o (slot_value_o),
      .byte_done_o  (byte_done),
      .rx_next_o    (rx_next),
      .tse_o        (tse),
      .rsf_o        (rsf)
   );

   ow_byte_rxbuf #(.BYTE_W(BYTE_W)) i_rxbuf (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .byte_done_i (byte_done),
      .rx_next_i   (rx_next),
      .rd_i        (rd_data),
      .data_o      (rx_data),
      .full_o      (rbf)
   );

   // flag order follows the status bit positions from ST_TX_BUF_EMPTY upward
   assign flag_v = {rsf, rbf, tse, tbe};

   for (genvar b = 0; b < REG_W; b++) begin : g_stat
      if (b >= ST_TX_BUF_EMPTY && b <= ST_MSB) begin : g_flag
         assign status_w[b] = flag_v[b - ST_TX_BUF_EMPTY];
      end else begin : g_zero
         assign status_w[b] = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                en_q <= '0;
      else if (reg_wr_i && sel_en) en_q <= reg_wdata_i & EN_MASK;
   end

   always_comb begin
      if (sel_data)      reg_rdata_o = REG_W'(rx_data);
      else if (sel_stat) reg_rdata_o = status_w;
      else if (sel_en)   reg_rdata_o = en_q;
      else               reg_rdata_o = '0;
   end

   assign irq_o = |(status_w & en_q);
endmodule

// File: tb/test_ow_byte_engine.sv
module test_ow_byte_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd1;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       slot_start, slot_value;
   logic       slot_done = 1'b0;
   logic       slot_bit = 1'b0;
   logic       irq;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   ow_byte_engine i_ow_byte_engine (
      .clk_i        (clk),
      .rst_n_i      (rst_n),
      .reg_wr_i     (reg_wr),
      .reg_rd_i     (reg_rd),
      .reg_addr_i   (reg_addr),
      .reg_wdata_i  (reg_wdata),
      .reg_rdata_o  (reg_rdata),
      .slot_start_o (slot_start),
      .slot_value_o (slot_value),
      .slot_done_i  (slot_done),
      .slot_bit_i   (slot_bit),
      .irq_o        (irq)
   );

   // ---------------- bus / slot responder ----------------
   int       lat = 2;
   int       r_cnt = 0;
   int       r_idx = 0;
   logic     r_val = 1'b0;
   logic [7:0] dev_byte = 8'hFF;
   bit       tx_q[$];

   always @(posedge clk) begin
      #1;
      slot_done = 1'b0;
      if (!rst_n) begin
         r_cnt = 0;
         r_idx = 0;
      end else begin
         if (r_cnt > 0) begin
            r_cnt--;
            if (r_cnt == 0) begin
               slot_done = 1'b1;
               slot_bit  = r_val & dev_byte[r_idx];   // open-drain: device may only pull low
               r_idx     = (r_idx + 1) % 8;
            end
         end
         if (slot_start) begin
            r_cnt = lat;
            r_val = slot_value;
         end
      end
   end

   always @(negedge clk) if (rst_n && slot_start) tx_q.push_back(slot_value);

   // ---------------- behavioural reference model ----------------
   bit   m_tbe = 1, m_tse = 1, m_rbf = 0, m_rsf = 0;
   int   m_st = 0;
   int   m_bit = 0;
   logic [7:0] m_txbuf = 0, m_cur = 0, m_acc = 0, m_rxdata = 0, m_en = 0;

   always @(posedge clk) begin : p_model
      bit ld, fin, lastb;
      int old;
      if (!rst_n) begin
         m_tbe = 1; m_tse = 1; m_rbf = 0; m_rsf = 0;
         m_st = 0; m_bit = 0; m_txbuf = 0; m_cur = 0; m_acc = 0; m_rxdata = 0; m_en = 0;
      end else begin
         old   = m_st;
         ld    = (old == 0) && !m_tbe;
         fin   = (old == 2) && slot_done;
         lastb = fin && (m_bit == 7);
         if (fin) m_acc[m_bit] = slot_bit;
         if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata & 8'h3C;
         if (lastb) begin
            m_rxdata = m_acc; m_rbf = 1; m_rsf = 1; m_tse = 1;
         end else if (reg_rd && reg_addr == 2'd0) m_rbf = 0;
         if (ld) begin
            m_cur = m_txbuf; m_tse = 0; m_rsf = 0; m_tbe = 1; m_bit = 0;
         end
         if (reg_wr && reg_addr == 2'd0) begin
            m_txbuf = reg_wdata; m_tbe = 0;
         end
         case (old)
            0: if (ld) m_st = 1;
            1: m_st = 2;
            default: if (fin) begin
               if (m_bit == 7) begin m_st = 0; m_bit = 0; end
               else begin m_st = 1; m_bit++; end
            end
         endcase
      end
   end

   function automatic logic [7:0] m_status();
      return {2'b00, m_rsf, m_rbf, m_tse, m_tbe, 2'b00};
   endfunction

   // every-cycle comparison
   always @(negedge clk) begin
      logic [7:0] exp_rd;
      if (rst_n) begin
         checks++;
         case (reg_addr)
            2'd0: exp_rd = m_rxdata;
            2'd1: exp_rd = m_status();
            2'd2: exp_rd = m_en;
            default: exp_rd = 8'h00;
         endcase
         if (reg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL R2 R6 R8 cycle rdata addr=%0d act=%h exp=%h", reg_addr, reg_rdata, exp_rd);
         end
         if (slot_start !== (m_st == 1)) begin
            errors++;
            $display("FAIL R3 cycle slot_start act=%b exp=%b", slot_start, (m_st == 1));
         end
         if ((m_st == 1) && slot_value !== m_cur[m_bit]) begin
            errors++;
            $display("FAIL R3 cycle slot_value act=%b exp=%b", slot_value, m_cur[m_bit]);
         end
         if (irq !== |(m_status() & m_en)) begin
            errors++;
            $display("FAIL R8 cycle irq act=%b exp=%b", irq, |(m_status() & m_en));
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_addr = 2'd1;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0; reg_addr = 2'd1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (m_st == 0 && m_tbe && r_cnt == 0) break;
      end
   endtask

   function automatic logic [7:0] seen_byte(input int base);
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[i] = tx_q[base + i];
      return v;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", reg_rdata, 8'h0C);
      chk("R1 irq after reset", {7'd0, irq}, 8'h00);
      chk("R1 slot_start after reset", {7'd0, slot_start}, 8'h00);
      rd_reg(2'd2, d);
      chk("R1 enable after reset", d, 8'h00);

      // R2 R3 R4: plain byte, bus free
      lat = 2; dev_byte = 8'hFF;
      wr_reg(2'd0, 8'hA5);
      @(negedge clk);
      chk("R2 tbe cleared by write", reg_rdata, 8'h08);
      @(negedge clk);
      chk("R2 shifter loaded", reg_rdata, 8'h04);
      chk("R3 first slot requested with bit0", {6'd0, slot_start, slot_value}, 8'h03);
      wait_idle();
      chk("R3 eight slots sent", 8'(tx_q.size()), 8'd8);
      chk("R3 lsb first order", seen_byte(0), 8'hA5);
      chk("R5 R6 R7 flags after byte", reg_rdata, 8'h3C);
      rd_reg(2'd0, d);
      chk("R4 echo on free bus", d, 8'hA5);
      @(negedge clk);
      chk("R6 read clears rx full", reg_rdata, 8'h2C);

      // R4: read by sending 0xFF, device pulls bits low
      lat = 1; dev_byte = 8'h3C;
      wr_reg(2'd0, 8'hFF);
      @(negedge clk);
      @(negedge clk);
      chk("R7 rx shifter full cleared on load", reg_rdata, 8'h04);
      wait_idle();
      rd_reg(2'd0, d);
      chk("R4 read byte via 0xFF", d, 8'h3C);
      dev_byte = 8'hF5;
      wr_reg(2'd0, 8'h0F);
      wait_idle();
      rd_reg(2'd0, d);
      chk("R4 write-0 slots read low", d, 8'h05);

      // R9: back-to-back bytes
      tx_q.delete();
      lat = 2; dev_byte = 8'hFF;
      wr_reg(2'd0, 8'h12);
      repeat (4) @(negedge clk);
      wr_reg(2'd0, 8'h34);
      @(negedge clk);
      chk("R9 second byte waits in buffer", reg_rdata & 8'h0C, 8'h00);
      rd_reg(2'd1, d);
      rd_reg(2'd1, d);
      chk("R9 status read no side effect", d & 8'h0C, 8'h00);
      wait_idle();
      chk("R9 sixteen slots sent", 8'(tx_q.size()), 8'd16);
      chk("R9 first byte order", seen_byte(0), 8'h12);
      chk("R9 second byte follows", seen_byte(8), 8'h34);

      // R6: read collides with completion, rx full left set from previous byte
      lat = 4; dev_byte = 8'h81;
      wr_reg(2'd0, 8'hFF);
      while (!(m_st == 2 && m_bit == 7 && r_cnt == 1)) @(negedge clk);
      @(posedge clk); #1;
      reg_addr = 2'd0; reg_rd = 1'b1;
      @(posedge clk); #1;
      reg_rd = 1'b0; reg_addr = 2'd1;
      @(negedge clk);
      chk("R6 completion wins over read", reg_rdata, 8'h3C);
      rd_reg(2'd0, d);
      chk("R6 new byte after collision", d, 8'h81);

      // R8: enable register and interrupt
      wr_reg(2'd2, 8'hFF);
      rd_reg(2'd2, d);
      chk("R8 enable keeps bits 2 to 5", d, 8'h3C);
      wr_reg(2'd2, 8'h10);
      @(negedge clk);
      chk("R8 irq low, rx empty", {7'd0, irq}, 8'h00);
      dev_byte = 8'hFF;
      wr_reg(2'd0, 8'h5A);
      wait_idle();
      chk("R8 irq on rx full", {7'd0, irq}, 8'h01);
      rd_reg(2'd0, d);
      @(negedge clk);
      chk("R8 irq drops after drain", {7'd0, irq}, 8'h00);
      wr_reg(2'd2, 8'h04);
      @(negedge clk);
      chk("R8 irq on tx empty", {7'd0, irq}, 8'h01);
      rd_reg(2'd3, d);
      chk("R8 unused address reads zero", d, 8'h00);
      wr_reg(2'd3, 8'hFF);
      @(negedge clk);
      chk("R8 unused address write ignored", reg_rdata, 8'h2C);

      repeat (3) @(posedge clk);
      report();
   end
endmodule